// File: doc/BRIEF.md
# Way-Tagged L2 Write Way-Enable Controller

This block sits between a write-through first-level data cache and an inclusive, set-associative second-level cache. A small table keeps one entry for each first-level line. The entry records which second-level way holds the copy of that line. When a line is filled from the second level, the supplying way is written into the table. When the second level evicts a line, the matching entry is cleared. This keeps the inclusion guarantee, so a stale way is never used.

Every first-level write also travels to the second level. The block reads the table in the same cycle as it accepts the write. It stores the resulting way code and a "known way" flag in the same queue entry as the write payload. When that entry drains, a decoder builds the per-way enable vector. If the flag is set, the vector enables exactly one way, so the second-level access behaves like a direct-mapped access. If the flag is clear, the vector enables every way. Read misses going to the second level never look at the table and always enable every way. Two counters record how many second-level accesses used a single way and how many used all ways.

Both the write input and the drain output are valid/ready streams. An item is taken on the input when `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the queue holds `BUF_DEPTH` entries. It stays low for that whole cycle, even if the head is popped in the same cycle. On the output, an entry is offered while `l2w_valid` is high. The offered entry must stay unchanged until `l2w_ready` is seen high.

Top module: `waytag_we_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block holds this state: every table entry invalid, queue empty (`l2w_valid`=0, `wr_ready`=1), both counters at 0, and `l2w_way_en`=0.
- R2: Take a line filled at index i with way code w. A later write with `wr_hit`=1 to index i drains with `l2w_way_en` equal to `1 << w`, meaning only bit w is set.
- R3: A write accepted with `wr_hit`=0 drains with every bit of `l2w_way_en` set. This holds even when the table entry for its index is valid.
- R4: A write with `wr_hit`=1 whose table entry is invalid drains with every way enabled. An entry is invalid if it was never filled or if it was cleared by an eviction.
- R5: An eviction pulse clears the entry at `evict_idx`. If a fill and an eviction name the same index in the same cycle, the fill takes effect.
- R6: The table lookup happens in the acceptance cycle and uses the table contents from before that cycle's clock edge. A fill or eviction that takes effect after acceptance does not change the enables of a write that is already queued.
- R7: Writes drain in acceptance order. Each write carries its own payload and its own enable vector. A write offered while `wr_ready` is low is not taken.
- R8: `wr_ready` is 0 exactly when `BUF_DEPTH` writes are queued. While `l2w_valid`=1 and `l2w_ready`=0, the payload and enables stay unchanged into the next cycle.
- R9: `rd_way_en` has every bit set in a cycle where `rd_miss_valid`=1, and is 0 otherwise. A read miss leaves the table unchanged.
- R10: `cnt_one_way` goes up by one for each drained write with one way enabled. `cnt_all_way` goes up by one for each drained all-way write and by one for each read-miss cycle. Both events may land in the same cycle, giving +2. Each update is visible one cycle after the event.
- R11: While `l2w_valid` is 0, `l2w_way_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | A line fill from the second level completes this cycle |
| fill_idx | input | IDX_W | First-level line index being filled |
| fill_way | input | WAY_W | Binary code of the second-level way that supplied the line |
| evict_valid | input | 1 | The second level evicts a line held at the first level |
| evict_idx | input | IDX_W | First-level line index whose entry is cleared |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Queue can take a write |
| wr_idx | input | IDX_W | First-level line index of the write |
| wr_hit | input | 1 | The write hit in the first level |
| wr_payload | input | PAYLOAD_W | Address/data carried to the second level |
| l2w_valid | output | 1 | Queued write offered to the second level |
| l2w_ready | input | 1 | Second level accepts the head write |
| l2w_payload | output | PAYLOAD_W | Payload of the head write |
| l2w_way_en | output | L2_WAYS | Way enables for the head write |
| rd_miss_valid | input | 1 | A read miss is sent to the second level this cycle |
| rd_way_en | output | L2_WAYS | Way enables for the read miss |
| cnt_one_way | output | CNT_W | Count of single-way second-level accesses |
| cnt_all_way | output | CNT_W | Count of all-way second-level accesses |

## Verification
The bench aims at these corner cases, each paired with the fault it exposes:

- Lookup of an index that was never filled: a design that trusts a reset-value way would enable a single, arbitrary way.
- Eviction, and a fill and eviction in the same cycle: a wrong priority would leave the entry invalid or stale.
- Table change after a write is queued: a design that looks the table up at drain time instead of acceptance would show the new way rather than the captured one.
- Full-queue stall with a write held on the input: a wrong full flag would overwrite or drop an entry and break drain order.
- Read miss and all-way drain in the same cycle: a counter that adds only one per cycle would lose an access.

// File: rtl/waytag_pkg.sv
package waytag_pkg;
  // How the decoder builds enables for one queued write
  typedef enum logic {
    EN_ALL_WAYS = 1'b0,
    EN_ONE_WAY  = 1'b1
  } way_mode_e;
endpackage

// File: rtl/waytag_array.sv
module waytag_array #(
  parameter int LINES = 16,
  parameter int WAY_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fill_valid,
  input  logic [$clog2(LINES)-1:0] fill_idx,
  input  logic [WAY_W-1:0]         fill_way,
  input  logic                     evict_valid,
  input  logic [$clog2(LINES)-1:0] evict_idx,
  input  logic [$clog2(LINES)-1:0] look_idx,
  output logic                     look_valid,
  output logic [WAY_W-1:0]         look_way
);
  localparam int IDX_W = $clog2(LINES);

  logic [LINES-1:0]            vld_q;
  logic [LINES-1:0][WAY_W-1:0] way_q;

  // A fill beats an eviction of the same entry in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      way_q <= '0;
    end else begin
      for (int e = 0; e < LINES; e++) begin
        if (fill_valid && fill_idx == IDX_W'(e)) begin
          vld_q[e] <= 1'b1;
          way_q[e] <= fill_way;
        end else if (evict_valid && evict_idx == IDX_W'(e)) begin
          vld_q[e] <= 1'b0;
        end
      end
    end
  end

  // Combinational read: no cycle added to the write path
  assign look_valid = vld_q[look_idx];
  assign look_way   = way_q[look_idx];
endmodule

// File: rtl/waytag_fifo.sv
module waytag_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push && !full)  wptr <= nxt(wptr);
      if (pop && !empty)  rptr <= nxt(rptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/way_decoder.sv
module way_decoder
  import waytag_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic                    offer,
  input  way_mode_e               mode,
  input  logic [$clog2(WAYS)-1:0] way,
  output logic [WAYS-1:0]         en
);
  localparam int WAY_W = $clog2(WAYS);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign en[g] = offer && ((mode == EN_ALL_WAYS) || (way == WAY_W'(g)));
  end
endmodule

// File: rtl/waytag_access_ctr.sv
module waytag_access_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             one_inc,
  input  logic [1:0]       all_inc,
  output logic [CNT_W-1:0] cnt_one,
  output logic [CNT_W-1:0] cnt_all
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_one <= '0;
      cnt_all <= '0;
    end else begin
      cnt_one <= cnt_one + CNT_W'(one_inc);
      cnt_all <= cnt_all + CNT_W'(all_inc);
    end
  end
endmodule

// File: rtl/waytag_we_ctrl.sv
module waytag_we_ctrl
  import waytag_pkg::*;
#(
  parameter int L1_LINES  = 16,
  parameter int L2_WAYS   = 4,
  parameter int BUF_DEPTH = 4,
  parameter int PAYLOAD_W = 32,
  parameter int CNT_W     = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fill_valid,
  input  logic [$clog2(L1_LINES)-1:0]   fill_idx,
  input  logic [$clog2(L2_WAYS)-1:0]    fill_way,
  input  logic                          evict_valid,
  input  logic [$clog2(L1_LINES)-1:0]   evict_idx,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [$clog2(L1_LINES)-1:0]   wr_idx,
  input  logic                          wr_hit,
  input  logic [PAYLOAD_W-1:0]          wr_payload,
  output logic                          l2w_valid,
  input  logic                          l2w_ready,
  output logic [PAYLOAD_W-1:0]          l2w_payload,
  output logic [L2_WAYS-1:0]            l2w_way_en,
  input  logic                          rd_miss_valid,
  output logic [L2_WAYS-1:0]            rd_way_en,
  output logic [CNT_W-1:0]              cnt_one_way,
  output logic [CNT_W-1:0]              cnt_all_way
);
  localparam int WAY_W = $clog2(L2_WAYS);
  localparam int ENT_W = 1 + WAY_W + PAYLOAD_W;

  logic             look_valid;
  logic [WAY_W-1:0] look_way;
  way_mode_e        push_mode, head_mode;
  logic [ENT_W-1:0] push_ent, head_ent;
  logic             q_full, q_empty, drain;

  waytag_array #(.LINES(L1_LINES), .WAY_W(WAY_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_way(fill_way),
    .evict_valid(evict_valid), .evict_idx(evict_idx),
    .look_idx(wr_idx), .look_valid(look_valid), .look_way(look_way)
  );

  // Way known only when the L1 write hit and the entry is valid
  assign push_mode = (wr_hit && look_valid) ? EN_ONE_WAY : EN_ALL_WAYS;
  assign push_ent  = {push_mode, look_way, wr_payload};

  assign wr_ready  = !q_full;
  assign l2w_valid = !q_empty;
  assign drain     = l2w_valid && l2w_ready;

  waytag_fifo #(.DEPTH(BUF_DEPTH), .W(ENT_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(wr_valid), .din(push_ent),
    .pop(l2w_ready), .dout(head_ent),
    .full(q_full), .empty(q_empty)
  );

  assign head_mode   = way_mode_e'(head_ent[ENT_W-1]);
  assign l2w_payload = head_ent[PAYLOAD_W-1:0];

  way_decoder #(.WAYS(L2_WAYS)) u_dec (
    .offer(l2w_valid), .mode(head_mode),
    .way(head_ent[PAYLOAD_W +: WAY_W]), .en(l2w_way_en)
  );

  // Read misses bypass the table entirely
  assign rd_way_en = {L2_WAYS{rd_miss_valid}};

  logic       one_inc;
  logic [1:0] all_inc;
  assign one_inc = drain && (head_mode == EN_ONE_WAY);
  assign all_inc = 2'(drain && (head_mode == EN_ALL_WAYS)) + 2'(rd_miss_valid);

  waytag_access_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .one_inc(one_inc), .all_inc(all_inc),
    .cnt_one(cnt_one_way), .cnt_all(cnt_all_way)
  );
endmodule

// File: rtl/waytag_we_ctrl_chk.sv
module waytag_we_ctrl_chk #(
  parameter int L2_WAYS   = 4,
  parameter int BUF_DEPTH = 4,
  parameter int PAYLOAD_W = 32,
  parameter int CNT_W     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_valid,
  input logic                 wr_ready,
  input logic                 l2w_valid,
  input logic                 l2w_ready,
  input logic [PAYLOAD_W-1:0] l2w_payload,
  input logic [L2_WAYS-1:0]   l2w_way_en,
  input logic                 rd_miss_valid,
  input logic [L2_WAYS-1:0]   rd_way_en,
  input logic [CNT_W-1:0]     cnt_one_way,
  input logic [CNT_W-1:0]     cnt_all_way
);
  localparam int OCC_W = $clog2(BUF_DEPTH + 1);
  localparam logic [L2_WAYS-1:0] ALL = '1;

  // Occupancy rebuilt from the port handshakes
  logic [OCC_W-1:0] occ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + OCC_W'(wr_valid && wr_ready) - OCC_W'(l2w_valid && l2w_ready);
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (!l2w_valid && wr_ready && cnt_one_way == '0 && cnt_all_way == '0));

  a_r8_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready == (occ != OCC_W'(BUF_DEPTH)));

  a_r7_valid_tracks_occ: assert property (@(posedge clk) disable iff (!rst_n)
    l2w_valid == (occ != '0));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (l2w_valid && !l2w_ready) |=> (l2w_valid && $stable(l2w_payload) && $stable(l2w_way_en)));

  a_r2_enable_shape: assert property (@(posedge clk) disable iff (!rst_n)
    l2w_valid |-> ($onehot(l2w_way_en) || l2w_way_en == ALL));

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !l2w_valid |-> (l2w_way_en == '0));

  a_r9_read_all: assert property (@(posedge clk) disable iff (!rst_n)
    rd_way_en == (rd_miss_valid ? ALL : '0));

  a_r10_one_count: assert property (@(posedge clk) disable iff (!rst_n)
    (l2w_valid && l2w_ready && $onehot(l2w_way_en)) |=> (cnt_one_way == $past(cnt_one_way) + 1'b1));

  a_r10_dual_all: assert property (@(posedge clk) disable iff (!rst_n)
    (l2w_valid && l2w_ready && l2w_way_en == ALL && rd_miss_valid)
      |=> (cnt_all_way == $past(cnt_all_way) + 2'd2));
endmodule

bind waytag_we_ctrl waytag_we_ctrl_chk #(
  .L2_WAYS(L2_WAYS), .BUF_DEPTH(BUF_DEPTH), .PAYLOAD_W(PAYLOAD_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .l2w_valid(l2w_valid), .l2w_ready(l2w_ready), .l2w_payload(l2w_payload),
  .l2w_way_en(l2w_way_en), .rd_miss_valid(rd_miss_valid), .rd_way_en(rd_way_en),
  .cnt_one_way(cnt_one_way), .cnt_all_way(cnt_all_way)
);

// File: tb/waytag_we_ctrl_test.sv
module waytag_we_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // vector: [12:11] op (0 fill, 1 evict, 2 write), [10:7] idx, [6] hit, [5:4] way, [3:0] expected enables
  localparam logic [12:0] VEC [NV] = '{
    {2'd2, 4'd3,  1'b1, 2'd0, 4'hF},
    {2'd0, 4'd3,  1'b0, 2'd2, 4'h0},
    {2'd2, 4'd3,  1'b1, 2'd0, 4'h4},
    {2'd2, 4'd3,  1'b0, 2'd0, 4'hF},
    {2'd0, 4'd5,  1'b0, 2'd0, 4'h0},
    {2'd2, 4'd5,  1'b1, 2'd0, 4'h1},
    {2'd0, 4'd15, 1'b0, 2'd3, 4'h0},
    {2'd2, 4'd15, 1'b1, 2'd0, 4'h8},
    {2'd1, 4'd3,  1'b0, 2'd0, 4'h0},
    {2'd2, 4'd3,  1'b1, 2'd0, 4'hF},
    {2'd0, 4'd3,  1'b0, 2'd1, 4'h0},
    {2'd2, 4'd3,  1'b1, 2'd0, 4'h2},
    {2'd0, 4'd5,  1'b0, 2'd3, 4'h0},
    {2'd2, 4'd5,  1'b1, 2'd0, 4'h8}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic fill_valid = 0, evict_valid = 0, wr_valid = 0, wr_hit = 0, l2w_ready = 0, rd_miss_valid = 0;
  logic [3:0] fill_idx = 0, evict_idx = 0, wr_idx = 0;
  logic [1:0] fill_way = 0;
  logic [31:0] wr_payload = 0;
  logic wr_ready, l2w_valid;
  logic [31:0] l2w_payload;
  logic [3:0] l2w_way_en, rd_way_en;
  logic [15:0] cnt_one_way, cnt_all_way;

  int checks = 0, failures = 0, exp_one = 0, exp_all = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  waytag_we_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_way(fill_way),
    .evict_valid(evict_valid), .evict_idx(evict_idx),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_hit(wr_hit),
    .wr_payload(wr_payload), .l2w_valid(l2w_valid), .l2w_ready(l2w_ready),
    .l2w_payload(l2w_payload), .l2w_way_en(l2w_way_en),
    .rd_miss_valid(rd_miss_valid), .rd_way_en(rd_way_en),
    .cnt_one_way(cnt_one_way), .cnt_all_way(cnt_all_way)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_fill(input logic [3:0] i, input logic [1:0] w);
    fill_valid = 1; fill_idx = i; fill_way = w; cyc(); fill_valid = 0;
  endtask

  task automatic do_evict(input logic [3:0] i);
    evict_valid = 1; evict_idx = i; cyc(); evict_valid = 0;
  endtask

  task automatic do_push(input logic [3:0] i, input logic h, input logic [31:0] p);
    wr_valid = 1; wr_idx = i; wr_hit = h; wr_payload = p; cyc(); wr_valid = 0;
  endtask

  task automatic pop_chk(input string req, input logic [3:0] en, input logic [31:0] p);
    chk({req, " valid"}, 32'(l2w_valid), 32'd1);
    chk({req, " enables"}, 32'(l2w_way_en), 32'(en));
    chk({req, " payload"}, l2w_payload, p);
    l2w_ready = 1; cyc(); l2w_ready = 0;
    if (en == 4'hF) exp_all++; else exp_one++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [12:0] v;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(wr_ready), 32'd1);
    rst_n = 1'b1;
    cyc();
    chk("R1 valid", 32'(l2w_valid), 32'd0);
    chk("R1 ready", 32'(wr_ready), 32'd1);
    chk("R1 one count", 32'(cnt_one_way), 32'd0);
    chk("R1 all count", 32'(cnt_all_way), 32'd0);
    chk("R11 idle enables", 32'(l2w_way_en), 32'd0);

    // Vector walk: fills, evictions, writes drained one at a time
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      case (v[12:11])
        2'd0: do_fill(v[10:7], v[5:4]);
        2'd1: do_evict(v[10:7]);
        default: begin
          do_push(v[10:7], v[6], 32'(i));
          if (v[3:0] != 4'hF)  pop_chk("R2", v[3:0], 32'(i));
          else if (!v[6])      pop_chk("R3", v[3:0], 32'(i));
          else                 pop_chk("R4", v[3:0], 32'(i));
          chk("R11 empty after drain", 32'(l2w_way_en), 32'd0);
        end
      endcase
    end
    chk("R10 one count", 32'(cnt_one_way), 32'(exp_one));
    chk("R10 all count", 32'(cnt_all_way), 32'(exp_all));

    // R5: same-cycle fill and eviction of index 7, fill wins
    fill_valid = 1; fill_idx = 7; fill_way = 1;
    evict_valid = 1; evict_idx = 7;
    cyc(); fill_valid = 0; evict_valid = 0;
    do_push(7, 1, 32'h70);
    pop_chk("R5", 4'h2, 32'h70);

    // R6: queued tag is captured at acceptance
    do_push(15, 1, 32'h100);
    do_evict(15);
    do_fill(15, 0);
    pop_chk("R6", 4'h8, 32'h100);
    do_push(15, 1, 32'h101);
    pop_chk("R6 new tag", 4'h1, 32'h101);

    // R7/R8: fill the queue, stall, drain in order
    do_push(3, 1, 32'hA0);
    do_push(5, 0, 32'hA1);
    do_push(15, 1, 32'hA2);
    do_push(9, 1, 32'hA3);
    chk("R8 full", 32'(wr_ready), 32'd0);
    wr_valid = 1; wr_idx = 3; wr_hit = 1; wr_payload = 32'hBAD;
    cyc();
    chk("R8 stall ready", 32'(wr_ready), 32'd0);
    chk("R8 stable payload", l2w_payload, 32'hA0);
    cyc(); wr_valid = 0;
    chk("R8 stable enables", 32'(l2w_way_en), 32'h2);
    pop_chk("R7", 4'h2, 32'hA0);
    chk("R8 ready after pop", 32'(wr_ready), 32'd1);
    pop_chk("R7", 4'hF, 32'hA1);
    pop_chk("R7", 4'h1, 32'hA2);
    pop_chk("R7", 4'hF, 32'hA3);
    chk("R7 stalled write dropped", 32'(l2w_valid), 32'd0);

    // R9/R10: read miss together with an all-way drain
    do_push(9, 0, 32'hC0);
    l2w_ready = 1; rd_miss_valid = 1;
    #1 chk("R9 read enables", 32'(rd_way_en), 32'hF);
    cyc(); l2w_ready = 0; rd_miss_valid = 0;
    exp_all += 2;
    #1 chk("R9 idle read enables", 32'(rd_way_en), 32'h0);
    chk("R10 dual all count", 32'(cnt_all_way), 32'(exp_all));
    chk("R10 one count final", 32'(cnt_one_way), 32'(exp_one));
    do_push(3, 1, 32'hC1);
    pop_chk("R9 table untouched", 4'h2, 32'hC1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule